// File: doc/BRIEF.md
# Two-Key Parameter Entry Sequencer

This block lets an operator load a fixed series of configuration values into nonvolatile storage with only two keys: an increment key and an enter key. Immediately after reset it checks both keys. If both are held, it enters a programming session. Otherwise it hands control straight to normal operation, and the stored values stay as they are.

In a programming session, each value is edited as a six-digit decimal field with leading zeros. The increment key steps the digit under the cursor. The enter key moves the cursor right, and from the rightmost digit it completes the value. A completed value is converted to binary and clamped to the legal range for its parameter. It is then issued once, together with its parameter index, on a single-cycle write strobe. The digit field, cursor and current parameter index are outputs, so an external display can show a flashing cursor. After the last of nine parameters is written, the session ends and normal operation begins.

Top module: `param_entry_seq`

## Requirements
- R1: In the first clock after reset is released, the block enters programming (`prog_active_o`=1) if both keys are high, and otherwise enters normal operation (`normal_o`=1). The two flags are never both high.
- R2: While reset is asserted and right after it is released, every digit is 0, `cursor_o`=0, `cur_param_o`=0, `wr_en_o`=0, `prog_active_o`=0 and `normal_o`=0.
- R3: A rising edge of `key_inc_i` during programming increments the digit under the cursor, and 9 wraps to 0. All other digits are left unchanged.
- R4: A rising edge of `key_enter_i` with the cursor below 5 moves the cursor one place right. Cursor 0 is the most significant digit, and digit k occupies `digits_o[4k+3:4k]`.
- R5: A rising edge of `key_enter_i` with the cursor at 5 gives `wr_en_o` high for exactly one cycle, starting the cycle after that edge. In the same step all digits clear to 0, the cursor returns to 0 and the next parameter is selected.
- R6: Parameters are written with the indices 0 to 8 in this order: reference divider, channel spacing (kHz), maximum ratio, minimum ratio, offsets 1 to 4, start ratio. `param_idx_o` carries the index of the value being written, and `cur_param_o` carries the index being edited.
- R7: A reference divider (index 0) is written as its decimal value clamped to 4..32768.
- R8: Channel spacing is clamped to 1..1000. The maximum, minimum and start ratios (indices 2, 3, 8) are clamped to 40..65535. Offsets (indices 4 to 7) are clamped to 0..65535.
- R9: After index 8 is written, `normal_o` goes high and stays high, `prog_active_o` goes low, and no key has any further effect on the outputs.
- R10: If both keys rise in the same cycle, only the enter action takes place. A held key counts once.
- R11: Keys held through reset must be released before a press counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_inc_i | input | 1 | Digit increment key, debounced, high when pressed |
| key_enter_i | input | 1 | Enter/next key, debounced, high when pressed |
| prog_active_o | output | 1 | Programming session in progress |
| normal_o | output | 1 | Normal operation |
| digits_o | output | 24 | Six BCD digits, digit k at bits 4k+3:4k, digit 0 leftmost |
| cursor_o | output | 3 | Digit being edited, 0 to 5 |
| cur_param_o | output | 4 | Index of the parameter being edited |
| wr_en_o | output | 1 | One-cycle write strobe |
| param_idx_o | output | 4 | Index of the value being written |
| wr_data_o | output | 16 | Clamped binary value being written |

## Verification
One session loads values below the lower limit (2, 0, 12), values above the upper limit (999999, 99999), exact in-range values, and a zero offset. This separates a wrong BCD weighting from a wrong clamp bound and from a wrong per-index limit selection. A second session loads a value above the reference divider's upper limit and a start ratio one below its lower limit. It also opens with a simultaneous press of both keys, which separates enter priority from a double action. Ten increments on one digit show the 9-to-0 wrap. Sessions that start with the keys released, and presses made after the last write, show that keys have no effect outside programming.

// File: rtl/pes_pkg.sv
package pes_pkg;
  typedef enum logic [1:0] {ST_CHECK, ST_PROG, ST_DONE} pes_state_e;

  function automatic int param_lo(int idx);
    case (idx)
      0:             return 4;
      1:             return 1;
      2, 3, 8:       return 40;
      default:       return 0;
    endcase
  endfunction

  function automatic int param_hi(int idx);
    case (idx)
      0:       return 32768;
      1:       return 1000;
      default: return 65535;
    endcase
  endfunction
endpackage

// File: rtl/pes_key_edge.sv
module pes_key_edge #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] key_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_key
    logic prev_q;
    // reset to pressed: a key held through reset must be released first
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b1;
      else         prev_q <= key_i[g];
    end
    assign rise_o[g] = key_i[g] & ~prev_q;
  end
endmodule

// File: rtl/pes_digit_field.sv
module pes_digit_field #(
  parameter int NUM_DIGITS = 6,
  localparam int CUR_W = $clog2(NUM_DIGITS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    inc_i,
  input  logic                    adv_i,
  input  logic                    clr_i,
  output logic [4*NUM_DIGITS-1:0] digits_o,
  output logic [CUR_W-1:0]        cursor_o,
  output logic                    last_o
);
  logic [CUR_W-1:0] cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cur_q <= '0;
    else if (clr_i) cur_q <= '0;
    else if (adv_i) cur_q <= cur_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dig
    logic [3:0] d_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          d_q <= '0;
      else if (clr_i)                       d_q <= '0;
      else if (inc_i && cur_q == CUR_W'(k)) d_q <= (d_q == 4'd9) ? 4'd0 : d_q + 4'd1;
    end
    assign digits_o[4*k +: 4] = d_q;
  end

  assign cursor_o = cur_q;
  assign last_o   = (cur_q == CUR_W'(NUM_DIGITS - 1));
endmodule

// File: rtl/pes_bcd_to_bin.sv
module pes_bcd_to_bin #(
  parameter int NUM_DIGITS = 6,
  parameter int BIN_W      = 20
) (
  input  logic [4*NUM_DIGITS-1:0] digits_i,
  output logic [BIN_W-1:0]        value_o
);
  logic [BIN_W-1:0] acc [NUM_DIGITS+1];
  assign acc[0] = '0;
  // digit 0 is most significant: Horner chain left to right
  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_acc
    assign acc[k+1] = acc[k] * BIN_W'(10) + BIN_W'(digits_i[4*k +: 4]);
  end
  assign value_o = acc[NUM_DIGITS];
endmodule

// File: rtl/pes_clamp.sv
module pes_clamp #(
  parameter int BIN_W  = 20,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic [BIN_W-1:0]  value_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] data_o
);
  logic [BIN_W-1:0] lo, hi, sel;
  always_comb begin
    lo = BIN_W'(pes_pkg::param_lo(int'(idx_i)));
    hi = BIN_W'(pes_pkg::param_hi(int'(idx_i)));
    if (value_i < lo)      sel = lo;
    else if (value_i > hi) sel = hi;
    else                   sel = value_i;
  end
  assign data_o = DATA_W'(sel);
endmodule

// File: rtl/param_entry_seq.sv
module param_entry_seq #(
  parameter int NUM_DIGITS = 6,
  parameter int NUM_PARAMS = 9,
  parameter int DATA_W     = 16,
  localparam int CUR_W = $clog2(NUM_DIGITS),
  localparam int IDX_W = $clog2(NUM_PARAMS),
  localparam int BIN_W = $clog2(10 ** NUM_DIGITS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    key_inc_i,
  input  logic                    key_enter_i,
  output logic                    prog_active_o,
  output logic                    normal_o,
  output logic [4*NUM_DIGITS-1:0] digits_o,
  output logic [CUR_W-1:0]        cursor_o,
  output logic [IDX_W-1:0]        cur_param_o,
  output logic                    wr_en_o,
  output logic [IDX_W-1:0]        param_idx_o,
  output logic [DATA_W-1:0]       wr_data_o
);
  import pes_pkg::*;

  pes_state_e       state_q;
  logic [IDX_W-1:0] idx_q, wr_idx_q;
  logic             wr_en_q;
  logic [DATA_W-1:0] wr_data_q, clamped;
  logic [1:0]       rise;
  logic             prog, do_enter, do_inc, last, commit;
  logic [BIN_W-1:0] bin_val;

  pes_key_edge #(.N(2)) u_edge (
    .clk_i, .rst_ni,
    .key_i  ({key_enter_i, key_inc_i}),
    .rise_o (rise)
  );

  assign prog     = (state_q == ST_PROG);
  assign do_enter = prog & rise[1];
  assign do_inc   = prog & rise[0] & ~rise[1];  // enter wins a tie
  assign commit   = do_enter & last;

  pes_digit_field #(.NUM_DIGITS(NUM_DIGITS)) u_field (
    .clk_i, .rst_ni,
    .inc_i    (do_inc),
    .adv_i    (do_enter & ~last),
    .clr_i    (commit),
    .digits_o (digits_o),
    .cursor_o (cursor_o),
    .last_o   (last)
  );

  pes_bcd_to_bin #(.NUM_DIGITS(NUM_DIGITS), .BIN_W(BIN_W)) u_conv (
    .digits_i (digits_o),
    .value_o  (bin_val)
  );

  pes_clamp #(.BIN_W(BIN_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_clamp (
    .value_i (bin_val),
    .idx_i   (idx_q),
    .data_o  (clamped)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CHECK;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_CHECK: state_q <= (key_inc_i && key_enter_i) ? ST_PROG : ST_DONE;
        ST_PROG: if (commit) begin
          if (idx_q == IDX_W'(NUM_PARAMS - 1)) state_q <= ST_DONE;
          else                                 idx_q   <= idx_q + 1'b1;
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= commit;
      if (commit) begin
        wr_idx_q  <= idx_q;
        wr_data_q <= clamped;
      end
    end
  end

  assign prog_active_o = prog;
  assign normal_o      = (state_q == ST_DONE);
  assign cur_param_o   = idx_q;
  assign wr_en_o       = wr_en_q;
  assign param_idx_o   = wr_idx_q;
  assign wr_data_o     = wr_data_q;
endmodule

// File: rtl/param_entry_seq_chk.sv
module param_entry_seq_chk #(
  parameter int NUM_DIGITS = 6,
  parameter int NUM_PARAMS = 9,
  parameter int DATA_W     = 16,
  localparam int CUR_W = $clog2(NUM_DIGITS),
  localparam int IDX_W = $clog2(NUM_PARAMS)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    prog_active_o,
  input logic                    normal_o,
  input logic [4*NUM_DIGITS-1:0] digits_o,
  input logic [CUR_W-1:0]        cursor_o,
  input logic                    wr_en_o,
  input logic [IDX_W-1:0]        param_idx_o,
  input logic [DATA_W-1:0]       wr_data_o
);
  function automatic logic all_bcd(logic [4*NUM_DIGITS-1:0] d);
    for (int k = 0; k < NUM_DIGITS; k++)
      if (d[4*k +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  // R1
  excl_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_active_o && normal_o));

  // R3
  bcd_digits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_bcd(digits_o));

  // R4
  cursor_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cursor_o) < NUM_DIGITS);

  // R4
  cursor_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cursor_o != $past(cursor_o)) |-> (cursor_o == $past(cursor_o) + 1'b1 || cursor_o == '0));

  // R5
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  // R5
  wr_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(prog_active_o));

  // R8
  wr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (int'(wr_data_o) >= pes_pkg::param_lo(int'(param_idx_o)) &&
                 int'(wr_data_o) <= pes_pkg::param_hi(int'(param_idx_o))));

  // R9
  normal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    normal_o |=> (normal_o && !prog_active_o));
endmodule

bind param_entry_seq param_entry_seq_chk #(
  .NUM_DIGITS(NUM_DIGITS), .NUM_PARAMS(NUM_PARAMS), .DATA_W(DATA_W)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .prog_active_o (prog_active_o),
  .normal_o      (normal_o),
  .digits_o      (digits_o),
  .cursor_o      (cursor_o),
  .wr_en_o       (wr_en_o),
  .param_idx_o   (param_idx_o),
  .wr_data_o     (wr_data_o)
);

// File: tb/param_entry_seq_tb_top.sv
module param_entry_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_inc = 1'b0, key_enter = 1'b0;
  logic        prog_active, normal, wr_en;
  logic [23:0] digits;
  logic [2:0]  cursor;
  logic [3:0]  cur_param, param_idx;
  logic [15:0] wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  param_entry_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .key_inc_i(key_inc), .key_enter_i(key_enter),
    .prog_active_o(prog_active), .normal_o(normal), .digits_o(digits),
    .cursor_o(cursor), .cur_param_o(cur_param), .wr_en_o(wr_en),
    .param_idx_o(param_idx), .wr_data_o(wr_data)
  );

  int checks = 0, failures = 0;
  bit cmp_en = 1'b0, finished = 1'b0;

  // behavioural model
  int md[6];
  int mcur, midx, mwr_idx, mwr_data;
  bit mprog, mnorm, mwr;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int clampv(int v, int idx);
    int lo, hi;
    if (idx == 0)      begin lo = 4;  hi = 32768; end
    else if (idx == 1) begin lo = 1;  hi = 1000;  end
    else if (idx >= 4 && idx <= 7) begin lo = 0; hi = 65535; end
    else               begin lo = 40; hi = 65535; end
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic int field_value();
    int v = 0;
    for (int k = 0; k < 6; k++) v = v * 10 + md[k];
    return v;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 6; k++) md[k] = 0;
    mcur = 0;
  endtask

  task automatic model_apply(bit m, bit e);
    if (!mprog) return;
    if (e) begin
      if (mcur < 5) mcur++;
      else begin
        mwr = 1; mwr_idx = midx; mwr_data = clampv(field_value(), midx);
        model_clear();
        if (midx == 8) begin mprog = 0; mnorm = 1; end
        else midx++;
      end
    end else if (m) md[mcur] = (md[mcur] + 1) % 10;
  endtask

  always @(negedge clk) if (cmp_en) begin
    for (int k = 0; k < 6; k++)
      chk(int'(digits[4*k +: 4]) == md[k], "R3 digit", int'(digits[4*k +: 4]), md[k]);
    chk(int'(cursor) == mcur, "R4 cursor", int'(cursor), mcur);
    chk(int'(cur_param) == midx, "R6 cur_param", int'(cur_param), midx);
    chk(prog_active == mprog, "R1 prog_active", int'(prog_active), int'(mprog));
    chk(normal == mnorm, "R9 normal", int'(normal), int'(mnorm));
    chk(wr_en == mwr, "R5 wr_en", int'(wr_en), int'(mwr));
    if (mwr) begin
      chk(int'(param_idx) == mwr_idx, "R6 param_idx", int'(param_idx), mwr_idx);
      if (mwr_idx == 0) chk(int'(wr_data) == mwr_data, "R7 wr_data", int'(wr_data), mwr_data);
      else              chk(int'(wr_data) == mwr_data, "R8 wr_data", int'(wr_data), mwr_data);
    end
  end

  task automatic press(bit m, bit e);
    @(negedge clk); key_inc = m; key_enter = e;
    @(posedge clk); #1; model_apply(m, e);
    @(negedge clk); key_inc = 0; key_enter = 0;
    @(posedge clk); #1; mwr = 0;
  endtask

  task automatic enter_value(int v);
    for (int k = mcur; k < 6; k++) begin
      int dg = (v / (10 ** (5 - k))) % 10;
      int n = (dg - md[k] + 10) % 10;
      repeat (n) press(1, 0);
      press(0, 1);
    end
  endtask

  task automatic do_reset(bit held);
    cmp_en = 0;
    @(negedge clk); rst_n = 0; key_inc = held; key_enter = held;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    model_clear(); midx = 0; mprog = 0; mnorm = 0; mwr = 0;
    // R2 reset state
    chk(digits == '0, "R2 digits", int'(digits), 0);
    chk(cursor == '0 && cur_param == '0, "R2 cursor/param", int'(cursor), 0);
    chk(!wr_en && !prog_active && !normal, "R2 flags",
        int'({wr_en, prog_active, normal}), 0);
    @(posedge clk); #1; mprog = held; mnorm = !held; cmp_en = 1;
    if (held) begin
      repeat (3) @(posedge clk);  // keys still held: no edit (R11)
      @(negedge clk);
      chk(cursor == '0 && digits == '0, "R11 held keys", int'(cursor), 0);
      key_inc = 0; key_enter = 0;
      @(posedge clk); #1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // session A: lower clamps, upper clamps, wrap
    do_reset(1);
    chk(prog_active == 1'b1, "R1 prog entry", int'(prog_active), 1);
    repeat (10) press(1, 0);  // R3 wrap back to 0
    chk(digits[3:0] == 4'd0, "R3 wrap", int'(digits[3:0]), 0);
    enter_value(2);       // R7 -> 4
    enter_value(0);       // R8 spacing -> 1
    enter_value(999999);  // -> 65535
    enter_value(12);      // -> 40
    enter_value(428);
    enter_value(65108);
    enter_value(0);
    enter_value(99999);   // -> 65535
    enter_value(2000);
    @(negedge clk);
    chk(normal && !prog_active, "R9 done", int'(normal), 1);
    press(1, 0); press(0, 1); press(1, 1);  // R9 ignored
    chk(digits == '0 && cursor == '0, "R9 keys ignored", int'(cursor), 0);

    // no programming without both keys
    do_reset(0);
    @(negedge clk);
    chk(normal && !prog_active, "R1 normal entry", int'(normal), 1);
    press(1, 0); press(0, 1);

    // session B: upper ref clamp, tie priority, start ratio clamp
    do_reset(1);
    press(1, 1);  // R10 enter wins
    chk(cursor == 3'd1 && digits == '0, "R10 tie", int'(cursor), 1);
    enter_value(50000);   // R7 -> 32768
    enter_value(25);
    enter_value(2160);
    enter_value(2000);
    enter_value(452);
    enter_value(1);
    enter_value(2);
    enter_value(3);
    enter_value(39);      // R8 -> 40
    @(negedge clk);
    chk(normal == 1'b1, "R9 done B", int'(normal), 1);
    repeat (2) @(posedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule